// File: doc/BRIEF.md
# Cache Line Write-Policy State Controller

This block holds a two-bit coherence state for every line of a small on-chip data cache and decides, as each bus cycle completes, whether that line is handled as write-back or write-through. With each completed cycle the block receives the line index, the kind of cycle (a line fill or a memory write), the page-level write-through attribute, and the system's sampled write-back select input. It updates the stored state of the addressed line and presents the resulting state and policy on registered outputs.

Other cache logic reads a line's current state, and whether that line acts as write-back, through a separate combinational lookup port. The block does no tag matching, stores no data and does not snoop. It also never creates the Modified state itself. It only works on the state it holds for the addressed line.

Top module: `cpol_ctrl`

## Requirements
- R1: Synchronous active-high reset sets every line to Invalid (code 00) and clears `res_valid_o`, `res_state_o` and `res_wb_o`. State codes are Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: When a line fill completes with `pwt_i`=0 and `wbsel_i`=1, the line is stored as Exclusive (10).
- R3: When a line fill completes with `pwt_i`=1, the line is stored as Shared (01), whatever the value of `wbsel_i`.
- R4: When a line fill completes with `pwt_i`=0 and `wbsel_i`=0, the line is stored as Shared (01).
- R5: When a memory write completes to a Shared line with `pwt_i`=0 and `wbsel_i`=1, the line moves to Exclusive (10).
- R6: When a memory write completes to a Shared line with `wbsel_i`=0 or `pwt_i`=1, the line stays Shared.
- R7: A memory write to an Invalid line leaves that line Invalid.
- R8: A memory write to an Exclusive or Modified line leaves its state unchanged.
- R9: The inputs `kind_i`, `idx_i`, `pwt_i` and `wbsel_i` are sampled only on a rising edge where `done_i`=1, and the update takes effect on that edge. No other line changes, and cycles with `done_i`=0 change no state.
- R10: The lookup port is combinational. `lk_state_o` gives the stored state of line `lk_idx_i`, and `lk_wb_o` is 1 exactly when that state is Exclusive or Modified.
- R11: After each edge with `done_i`=1, `res_valid_o` is 1 for one cycle, and `res_state_o`/`res_wb_o` give the resulting state of the addressed line and whether that state is write-back. `res_valid_o` is 0 after any edge with `done_i`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Bus cycle completes on this edge |
| kind_i | input | 1 | Cycle kind: 0 line fill, 1 memory write |
| idx_i | input | IDX_W | Line index of the completing cycle |
| pwt_i | input | 1 | Page write-through attribute |
| wbsel_i | input | 1 | System write-back select sample (1 asks for write-back) |
| res_valid_o | output | 1 | Result strobe, one cycle per completed cycle |
| res_state_o | output | 2 | Resulting state of the addressed line |
| res_wb_o | output | 1 | Resulting line behaves as write-back |
| lk_idx_i | input | IDX_W | Lookup line index |
| lk_state_o | output | 2 | Current state of the looked-up line |
| lk_wb_o | output | 1 | Looked-up line behaves as write-back |

## Verification
The assertions check the following on every cycle: the fill outcomes for the write-back and the page write-through cases, that writes to Invalid or already write-back lines keep their state, and that the result strobe follows the completion strobe exactly one cycle later. Some behaviour is visible only through the bench's sweeps and the lookup port. This covers the Shared-to-Exclusive promotion under every attribute combination, lines other than the addressed one keeping their state, and stimulus with `done_i` low leaving the stored states untouched.

// File: rtl/cpol_pkg.sv
package cpol_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } line_st_t;

  typedef enum logic {
    CYC_FILL  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_kind_t;

endpackage

// File: rtl/cpol_policy.sv
module cpol_policy
  import cpol_pkg::*;
(
  input  cyc_kind_t kind,
  input  line_st_t  cur,
  input  logic      pwt,
  input  logic      wbsel,
  output line_st_t  nxt,
  output logic      we
);

  logic wb_ok;

  always_comb begin
    wb_ok = !pwt && wbsel;
    nxt   = cur;
    we    = 1'b0;
    case (kind)
      CYC_FILL: begin
        nxt = wb_ok ? ST_EXC : ST_SHR;
        we  = 1'b1;
      end
      CYC_WRITE: begin
        if (cur == ST_SHR) begin
          nxt = wb_ok ? ST_EXC : ST_SHR;
          we  = 1'b1;
        end
      end
      default: begin
        nxt = cur;
        we  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cpol_line_store.sv
module cpol_line_store
  import cpol_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_st,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_t         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_t         rd_b_st
);

  line_st_t             q [NUM_LINES];
  logic [NUM_LINES-1:0] wsel;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_wdec
    assign wsel[g] = we && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) q[i] <= ST_INV;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wsel[i]) q[i] <= wr_st;
      end
    end
  end

  assign rd_a_st = q[rd_a_idx];
  assign rd_b_st = q[rd_b_idx];

endmodule

// File: rtl/cpol_result.sv
module cpol_result
  import cpol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  line_st_t   st_in,
  output logic       res_valid,
  output logic [1:0] res_state,
  output logic       res_wb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_state <= 2'b00;
      res_wb    <= 1'b0;
    end else begin
      res_valid <= done;
      if (done) begin
        res_state <= st_in;
        res_wb    <= (st_in == ST_EXC) || (st_in == ST_MOD);
      end
    end
  end

endmodule

// File: rtl/cpol_ctrl.sv
module cpol_ctrl
  import cpol_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic             kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pwt_i,
  input  logic             wbsel_i,
  output logic             res_valid_o,
  output logic [1:0]       res_state_o,
  output logic             res_wb_o,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [1:0]       lk_state_o,
  output logic             lk_wb_o
);

  line_st_t cur_st;
  line_st_t nxt_st;
  line_st_t lk_st;
  logic     pol_we;

  cpol_line_store #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (done_i && pol_we),
    .wr_idx  (idx_i),
    .wr_st   (nxt_st),
    .rd_a_idx(idx_i),
    .rd_a_st (cur_st),
    .rd_b_idx(lk_idx_i),
    .rd_b_st (lk_st)
  );

  cpol_policy u_policy (
    .kind (cyc_kind_t'(kind_i)),
    .cur  (cur_st),
    .pwt  (pwt_i),
    .wbsel(wbsel_i),
    .nxt  (nxt_st),
    .we   (pol_we)
  );

  cpol_result u_result (
    .clk      (clk),
    .rst      (rst),
    .done     (done_i),
    .st_in    (nxt_st),
    .res_valid(res_valid_o),
    .res_state(res_state_o),
    .res_wb   (res_wb_o)
  );

  assign lk_state_o = lk_st;
  assign lk_wb_o    = (lk_st == ST_EXC) || (lk_st == ST_MOD);

  // R2
  fill_wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !kind_i && !pwt_i && wbsel_i) |=> (res_state_o == 2'b10 && res_wb_o));

  // R3
  fill_pwt_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !kind_i && pwt_i) |=> (res_state_o == 2'b01 && !res_wb_o));

  // R7
  write_inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && kind_i && cur_st == ST_INV) |=> (res_state_o == 2'b00 && !res_wb_o));

  // R8
  write_wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && kind_i && (cur_st == ST_EXC || cur_st == ST_MOD)) |=> (res_state_o == $past(cur_st)));

  // R11
  res_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> res_valid_o);

  // R11
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> !res_valid_o);

endmodule

// File: tb/cpol_ctrl_tb.sv
module cpol_ctrl_tb;

  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          done_i = 1'b0;
  logic          kind_i = 1'b0;
  logic [IW-1:0] idx_i = '0;
  logic          pwt_i = 1'b0;
  logic          wbsel_i = 1'b0;
  logic          res_valid_o;
  logic [1:0]    res_state_o;
  logic          res_wb_o;
  logic [IW-1:0] lk_idx_i = '0;
  logic [1:0]    lk_state_o;
  logic          lk_wb_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] model [N];

  always #10 clk = ~clk;

  cpol_ctrl #(.NUM_LINES(N)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .done_i     (done_i),
    .kind_i     (kind_i),
    .idx_i      (idx_i),
    .pwt_i      (pwt_i),
    .wbsel_i    (wbsel_i),
    .res_valid_o(res_valid_o),
    .res_state_o(res_state_o),
    .res_wb_o   (res_wb_o),
    .lk_idx_i   (lk_idx_i),
    .lk_state_o (lk_state_o),
    .lk_wb_o    (lk_wb_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(int i, string req);
    lk_idx_i = i[IW-1:0];
    #1;
    chk(req, int'(lk_state_o), int'(model[i]));
    chk(req, int'(lk_wb_o), int'(model[i][1]));
  endtask

  task automatic op(bit kind, int i, bit pwt, bit wb);
    logic [1:0] exp;
    string req;
    if (!kind) begin
      exp = (!pwt && wb) ? 2'b10 : 2'b01;
      req = pwt ? "R3" : (wb ? "R2" : "R4");
    end else if (model[i] == 2'b01) begin
      exp = (!pwt && wb) ? 2'b10 : 2'b01;
      req = (!pwt && wb) ? "R5" : "R6";
    end else begin
      exp = model[i];
      req = (model[i] == 2'b00) ? "R7" : "R8";
    end
    @(negedge clk);
    done_i  = 1'b1;
    kind_i  = kind;
    idx_i   = i[IW-1:0];
    pwt_i   = pwt;
    wbsel_i = wb;
    @(negedge clk);
    done_i  = 1'b0;
    model[i] = exp;
    chk("R11", int'(res_valid_o), 1);
    chk(req, int'(res_state_o), int'(exp));
    chk(req, int'(res_wb_o), int'(exp[1]));
    look(i, req);
    look((i + 1) % N, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", int'(res_valid_o), 0);
    chk("R1", int'(res_state_o), 0);
    chk("R1", int'(res_wb_o), 0);
    for (int i = 0; i < N; i++) look(i, "R1");

    // R7: writes to every Invalid line under every attribute pair
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 4; c++) op(1'b1, i, c[1], c[0]);

    // R2..R8: fill then two writes, every combination per line
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 4; f++)
        for (int w = 0; w < 4; w++) begin
          op(1'b0, i, f[1], f[0]);
          op(1'b1, i, w[1], w[0]);
          op(1'b1, i, w[1], w[0]);
        end

    // R9: stimulus without done_i changes nothing
    op(1'b0, 3, 1'b1, 1'b0);
    @(negedge clk);
    kind_i = 1'b0; idx_i = IW'(3); pwt_i = 1'b0; wbsel_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", int'(res_valid_o), 0);
    look(3, "R9");
    kind_i = 1'b1;
    repeat (2) @(negedge clk);
    look(3, "R9");
    chk("R11", int'(res_valid_o), 0);

    // R10: final lookup sweep
    for (int i = 0; i < N; i++) look(i, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule